// File: doc/BRIEF.md
# Dead-Time Filtered Victim Cache

This block is a small fully associative victim cache that sits next to a direct-mapped L1 data cache. It only keeps lines that were evicted soon after their last use. Those lines are the ones likely to have been pushed out by a mapping conflict, so they are likely to be wanted again soon.

For every L1 frame the block keeps a coarse idle counter. An access or a fill to the frame clears its counter. A shared divider raises a tick every `TICK_PERIOD` cycles, and each tick adds one to every counter. When the L1 reports an eviction, the block reads the evicted frame's counter. If the counter is at or below `ADMIT_MAX`, the line goes into the victim store. Otherwise the line is dropped.

On an L1 miss, the L1 presents the line address as a lookup. A hit returns the stored line and frees the entry. Two running totals count admitted and refused evictions.

Top module: `dtf_victim_cache`

## Requirements
- R1: Every eviction request produces exactly one decision pulse one cycle later: either `admit_o` or `reject_o`, never both and never neither. A cycle without an eviction request produces no pulse.
- R2: An access or a fill on a frame clears that frame's idle counter at the same clock edge. An eviction presented in that same cycle reads the counter value from before the clear.
- R3: A global tick occurs at every `TICK_PERIOD`-th clock edge after reset release, counting the first edge as edge 1; with the default of 512, the ticks fall on edges 512, 1024, and so on. A tick adds one to every idle counter that is not being cleared.
- R4: An evicted line is admitted only when its frame's counter reads at most `ADMIT_MAX` (default 1), which means a dead time below 1024 cycles. A refused line never appears in the store: a later lookup of it misses.
- R5: Idle counters saturate at 2^`CNT_W`-1 (default 3) and never wrap. A frame idle for five ticks is therefore refused.
- R6: A lookup reports `lookup_hit_o` and `lookup_data_o` one cycle later. A hit removes the entry, so an immediate second lookup of the same address misses.
- R7: The store holds `ENTRIES` lines (default 32) at any positions. An insertion takes a free entry if one exists. Otherwise it replaces the entry that was least recently inserted or refreshed.
- R8: Admitting an address that is already stored overwrites that entry's data and marks it most recent. No duplicate entry is created.
- R9: `admit_cnt_o` and `reject_cnt_o` each increase by one in the same cycle as the matching decision pulse.
- R10: After reset the store is empty, all idle counters are zero, and the pulses and totals are zero.
- R11: A lookup and an admission in the same cycle are both honoured. The lookup sees the contents from before the insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | L1 access to a frame |
| acc_frame_i | input | IDX_W | Frame of the access |
| fill_vld_i | input | 1 | New line filled into a frame |
| fill_frame_i | input | IDX_W | Frame of the fill |
| evict_vld_i | input | 1 | Line leaving the L1 |
| evict_frame_i | input | IDX_W | Frame of the evicted line |
| evict_addr_i | input | ADDR_W | Line address of the evicted line |
| evict_data_i | input | DATA_W | Data of the evicted line |
| lookup_vld_i | input | 1 | Victim lookup on an L1 miss |
| lookup_addr_i | input | ADDR_W | Line address looked up |
| lookup_hit_o | output | 1 | Lookup hit, one cycle after the request |
| lookup_data_o | output | DATA_W | Data returned on a hit |
| admit_o | output | 1 | Last eviction was admitted |
| reject_o | output | 1 | Last eviction was refused |
| admit_cnt_o | output | STAT_W | Total admitted evictions |
| reject_cnt_o | output | STAT_W | Total refused evictions |

## Verification
Three results each appear at the first clock edge after their request: the decision pulse, the totals and the lookup response. The bench drives every request on a falling edge, holds it through one rising edge, and reads the result on the following falling edge.

Idle counters are observed only through admission decisions. The bench therefore counts rising edges from reset release, and this count gives the phase of each tick. Evictions are placed on exact edges around a tick: one edge before it, on it, and after one, two or five ticks. At each of those edges the expected counter value follows directly from R3 and R5.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_NONE   = 2'd0,
    VC_ADMIT  = 2'd1,
    VC_REJECT = 2'd2
  } vc_dec_e;
endpackage

// File: rtl/vc_tick_gen.sv
module vc_tick_gen #(
  parameter int PERIOD = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DIV_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(PERIOD - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

  generate
    if (PERIOD > 1) begin : g_chk
      // R3
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/vc_dead_timer.sv
module vc_dead_timer #(
  parameter int FRAMES = 64,
  parameter int CNT_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      clr_a_vld_i,
  input  logic [$clog2(FRAMES)-1:0] clr_a_idx_i,
  input  logic                      clr_b_vld_i,
  input  logic [$clog2(FRAMES)-1:0] clr_b_idx_i,
  input  logic [$clog2(FRAMES)-1:0] rd_idx_i,
  output logic [CNT_W-1:0]          rd_cnt_o
);
  localparam int IDX_W = $clog2(FRAMES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [FRAMES];
  logic [FRAMES-1:0] clr;

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    assign clr[g] = (clr_a_vld_i && (clr_a_idx_i == IDX_W'(g))) ||
                    (clr_b_vld_i && (clr_b_idx_i == IDX_W'(g)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q[g] <= '0;
      else if (clr[g])                      cnt_q[g] <= '0;
      else if (tick_i && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    // R5
    cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[g] == CNT_MAX && !clr[g]) |=> cnt_q[g] == CNT_MAX);
    // R2
    cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr[g] |=> cnt_q[g] == '0);
    // R3
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !clr[g]) |=> $stable(cnt_q[g]));
  end

  assign rd_cnt_o = cnt_q[rd_idx_i];
endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [DATA_W-1:0] ins_data_i,
  input  logic              lk_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);
  localparam int AGE_W = $clog2(ENTRIES);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, valid_n;
  logic [AGE_W-1:0]   age_q  [ENTRIES];
  logic [AGE_W-1:0]   age_n  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ADDR_W-1:0]  addr_n [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [DATA_W-1:0]  data_n [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [AGE_W-1:0]   hit_idx;
  logic [DATA_W-1:0]  hit_data;
  logic               m_any, f_any;
  logic [AGE_W-1:0]   m_idx, f_idx, o_idx, tgt;
  logic [AGE_W:0]     tage;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = lk_i && valid_q[e] && (addr_q[e] == lk_addr_i);
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    hit_data = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit_vec[e] && !hit_any) begin
        hit_any  = 1'b1;
        hit_idx  = AGE_W'(e);
        hit_data = data_q[e];
      end
    end
  end

  // removal by lookup first, insertion applied on top of it
  always_comb begin
    valid_n = valid_q;
    age_n   = age_q;
    addr_n  = addr_q;
    data_n  = data_q;
    m_any = 1'b0; f_any = 1'b0;
    m_idx = '0; f_idx = '0; o_idx = '0; tgt = '0; tage = '0;
    if (hit_any) begin
      valid_n[hit_idx] = 1'b0;
      for (int e = 0; e < ENTRIES; e++)
        if (valid_q[e] && age_q[e] > age_q[hit_idx]) age_n[e] = age_q[e] - 1'b1;
    end
    if (ins_i) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (valid_n[e] && addr_q[e] == ins_addr_i && !m_any) begin
          m_any = 1'b1; m_idx = AGE_W'(e);
        end
        if (!valid_n[e] && !f_any) begin
          f_any = 1'b1; f_idx = AGE_W'(e);
        end
        if (age_n[e] == OLDEST) o_idx = AGE_W'(e);
      end
      if (m_any) begin
        tgt = m_idx; tage = {1'b0, age_n[m_idx]};
      end else if (f_any) begin
        tgt = f_idx; tage = (AGE_W+1)'(ENTRIES);
      end else begin
        tgt = o_idx; tage = {1'b0, OLDEST};
      end
      for (int e = 0; e < ENTRIES; e++)
        if (valid_n[e] && {1'b0, age_n[e]} < tage) age_n[e] = age_n[e] + 1'b1;
      valid_n[tgt] = 1'b1;
      age_n[tgt]   = '0;
      addr_n[tgt]  = ins_addr_i;
      data_n[tgt]  = ins_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        age_q[e]  <= '0;
        addr_q[e] <= '0;
        data_q[e] <= '0;
      end
      lk_hit_o  <= 1'b0;
      lk_data_o <= '0;
    end else begin
      valid_q   <= valid_n;
      age_q     <= age_n;
      addr_q    <= addr_n;
      data_q    <= data_n;
      lk_hit_o  <= hit_any;
      lk_data_o <= hit_data;
    end
  end

  // R8
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R7
  full_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_q && ins_i && !hit_any) |=> &valid_q);
  // R6
  hit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> $past(lk_i));
  // R7
  ins_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> |valid_q);
endmodule

// File: rtl/dtf_victim_cache.sv
module dtf_victim_cache #(
  parameter int FRAMES      = 64,
  parameter int CNT_W       = 2,
  parameter int TICK_PERIOD = 512,
  parameter int ADMIT_MAX   = 1,
  parameter int ENTRIES     = 32,
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 64,
  parameter int STAT_W      = 16,
  localparam int IDX_W      = $clog2(FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_vld_i,
  input  logic [IDX_W-1:0]  acc_frame_i,
  input  logic              fill_vld_i,
  input  logic [IDX_W-1:0]  fill_frame_i,
  input  logic              evict_vld_i,
  input  logic [IDX_W-1:0]  evict_frame_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  input  logic              lookup_vld_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_hit_o,
  output logic [DATA_W-1:0] lookup_data_o,
  output logic              admit_o,
  output logic              reject_o,
  output logic [STAT_W-1:0] admit_cnt_o,
  output logic [STAT_W-1:0] reject_cnt_o
);
  import vc_pkg::*;

  localparam logic [CNT_W-1:0] ADMIT_LIM = CNT_W'(ADMIT_MAX);

  logic             tick;
  logic [CNT_W-1:0] dead_cnt;
  logic             admit;
  vc_dec_e          dec_d, dec_q;

  vc_tick_gen #(.PERIOD(TICK_PERIOD)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  vc_dead_timer #(.FRAMES(FRAMES), .CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clr_a_vld_i(acc_vld_i),
    .clr_a_idx_i(acc_frame_i),
    .clr_b_vld_i(fill_vld_i),
    .clr_b_idx_i(fill_frame_i),
    .rd_idx_i   (evict_frame_i),
    .rd_cnt_o   (dead_cnt)
  );

  assign admit = evict_vld_i && (dead_cnt <= ADMIT_LIM);

  always_comb begin
    if (!evict_vld_i) dec_d = VC_NONE;
    else if (admit)   dec_d = VC_ADMIT;
    else              dec_d = VC_REJECT;
  end

  vc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_i     (admit),
    .ins_addr_i(evict_addr_i),
    .ins_data_i(evict_data_i),
    .lk_i      (lookup_vld_i),
    .lk_addr_i (lookup_addr_i),
    .lk_hit_o  (lookup_hit_o),
    .lk_data_o (lookup_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q        <= VC_NONE;
      admit_cnt_o  <= '0;
      reject_cnt_o <= '0;
    end else begin
      dec_q <= dec_d;
      if (dec_d == VC_ADMIT)  admit_cnt_o  <= admit_cnt_o + 1'b1;
      if (dec_d == VC_REJECT) reject_cnt_o <= reject_cnt_o + 1'b1;
    end
  end

  assign admit_o  = (dec_q == VC_ADMIT);
  assign reject_o = (dec_q == VC_REJECT);

  // R1
  one_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_vld_i |=> (admit_o ^ reject_o));
  // R1
  no_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_vld_i |=> !(admit_o || reject_o));
  // R9
  adm_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_vld_i |=> admit_o ? (admit_cnt_o == $past(admit_cnt_o) + 1'b1)
                            : (reject_cnt_o == $past(reject_cnt_o) + 1'b1));
endmodule

// File: tb/test_dtf_victim_cache.sv
module test_dtf_victim_cache;
  localparam int P = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_vld = 0, fill_vld = 0, evict_vld = 0, lookup_vld = 0;
  logic [5:0]  acc_frame = 0, fill_frame = 0, evict_frame = 0;
  logic [25:0] evict_addr = 0, lookup_addr = 0;
  logic [63:0] evict_data = 0;
  logic        lookup_hit, admit, reject;
  logic [63:0] lookup_data;
  logic [15:0] admit_cnt, reject_cnt;

  int cyc = 0, checks = 0, fails = 0, exp_adm = 0, exp_rej = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  dtf_victim_cache i_dtf_victim_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_vld_i(acc_vld), .acc_frame_i(acc_frame),
    .fill_vld_i(fill_vld), .fill_frame_i(fill_frame),
    .evict_vld_i(evict_vld), .evict_frame_i(evict_frame),
    .evict_addr_i(evict_addr), .evict_data_i(evict_data),
    .lookup_vld_i(lookup_vld), .lookup_addr_i(lookup_addr),
    .lookup_hit_o(lookup_hit), .lookup_data_o(lookup_data),
    .admit_o(admit), .reject_o(reject),
    .admit_cnt_o(admit_cnt), .reject_cnt_o(reject_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dat(input int i);
    return {32'hDA7A_0000 + i[31:0], 32'h0F0F_0000 ^ i[31:0]};
  endfunction

  task automatic access(input int f);
    acc_vld = 1; acc_frame = 6'(f);
    @(negedge clk);
    acc_vld = 0;
  endtask

  task automatic wait_tick;
    do @(negedge clk); while (cyc % P != 0);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  // one eviction, optional same-cycle access/fill to the same frame, optional lookup
  task automatic evict(input int f, input logic [25:0] a, input logic [63:0] d,
                       input bit exp_admit, input string req,
                       input bit with_acc = 0, input bit with_fill = 0);
    evict_vld = 1; evict_frame = 6'(f); evict_addr = a; evict_data = d;
    acc_vld = with_acc; acc_frame = 6'(f);
    fill_vld = with_fill; fill_frame = 6'(f);
    @(negedge clk);
    evict_vld = 0; acc_vld = 0; fill_vld = 0;
    if (exp_admit) exp_adm++; else exp_rej++;
    chk(admit == exp_admit && reject == !exp_admit, req, {62'd0, admit, reject},
        {62'd0, exp_admit, !exp_admit});
    chk(admit_cnt == 16'(exp_adm) && reject_cnt == 16'(exp_rej), "R9",
        {32'd0, admit_cnt, reject_cnt}, {32'd0, 16'(exp_adm), 16'(exp_rej)});
  endtask

  task automatic lookup(input logic [25:0] a, input bit exp_hit, input logic [63:0] exp_d,
                        input string req);
    lookup_vld = 1; lookup_addr = a;
    @(negedge clk);
    lookup_vld = 0;
    chk(lookup_hit == exp_hit, req, {63'd0, lookup_hit}, {63'd0, exp_hit});
    if (exp_hit) chk(lookup_data == exp_d, req, lookup_data, exp_d);
  endtask

  task automatic t_reset;
    chk(!lookup_hit && !admit && !reject, "R10", {61'd0, lookup_hit, admit, reject}, 64'd0);
    chk(admit_cnt == 0 && reject_cnt == 0, "R10", {32'd0, admit_cnt, reject_cnt}, 64'd0);
    @(negedge clk);
    chk(!admit && !reject, "R1 idle", {62'd0, admit, reject}, 64'd0);
    lookup(26'h100, 0, 0, "R10 empty");
  endtask

  task automatic t_capacity;
    for (int i = 0; i <= 32; i++) evict(0, 26'h100 + 26'(i), dat(i), 1, "R7 insert", 0, 1);
    lookup(26'h100, 0, 0, "R7 oldest replaced");
    lookup(26'h120, 1, dat(32), "R7 newest kept");
    lookup(26'h101, 1, dat(1), "R6 hit");
    lookup(26'h101, 0, 0, "R6 removed");
    evict(0, 26'h200, dat(200), 1, "R7 free slot", 0, 1);
    lookup(26'h102, 1, dat(2), "R7 free slot used");
  endtask

  task automatic t_refresh;
    evict(0, 26'h103, dat(77), 1, "R8 re-admit", 0, 1);
    lookup(26'h103, 1, dat(77), "R8 overwrite");
    lookup(26'h103, 0, 0, "R8 no duplicate");
  endtask

  task automatic t_same_cycle;
    lookup_vld = 1; lookup_addr = 26'h300;
    evict(0, 26'h300, dat(300), 1, "R11 admit", 0, 1);
    lookup_vld = 0;
    chk(!lookup_hit, "R11 lookup sees old", {63'd0, lookup_hit}, 64'd0);
    lookup(26'h300, 1, dat(300), "R11 later hit");
  endtask

  task automatic t_dead;
    wait_tick;
    access(5);
    evict(5, 26'h500, dat(500), 1, "R4 dead 0");
    lookup(26'h500, 1, dat(500), "R4 dead 0 stored");
    access(6); wait_tick;
    evict(6, 26'h600, dat(600), 1, "R4 dead 1");
    access(7); wait_tick; wait_tick;
    evict(7, 26'h700, dat(700), 0, "R4 dead 2");
    lookup(26'h700, 0, 0, "R4 refused absent");
    access(8);
    for (int k = 0; k < 5; k++) wait_tick;
    evict(8, 26'h800, dat(800), 0, "R5 saturate");
    lookup(26'h800, 0, 0, "R5 refused absent");
  endtask

  task automatic t_clear_order;
    access(9); wait_tick; wait_tick;
    evict(9, 26'h900, dat(900), 0, "R2 acc same cycle old value", 1, 0);
    evict(9, 26'h901, dat(901), 1, "R2 acc cleared");
    evict(10, 26'hA00, dat(1000), 0, "R2 fill same cycle old value", 0, 1);
    evict(10, 26'hA01, dat(1001), 1, "R2 fill cleared");
  endtask

  task automatic t_tick_phase;
    int t0;
    wait_tick;
    t0 = cyc;
    acc_vld = 1; acc_frame = 6'd12;
    fill_vld = 1; fill_frame = 6'd13;
    @(negedge clk);
    acc_vld = 0; fill_vld = 0;
    wait_cyc(t0 + 2*P - 1);
    evict(12, 26'hC00, dat(1200), 1, "R3 before second tick");
    evict(13, 26'hD00, dat(1300), 0, "R3 after second tick");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_capacity;
    t_refresh;
    t_same_cycle;
    t_dead;
    t_clear_order;
    t_tick_phase;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule